// File: doc/BRIEF.md
# Double-Buffered PLL Divider Pair

This block holds the reference divider and the feedback divider of an integer-N frequency synthesizer, followed by a small up/down phase-frequency detector. All logic runs on a fast system clock. The reference input and the feedback input are sampled as levels. The reference divider counts rising edges of the reference input. The feedback divider counts rising edges of the feedback input. Each divider emits a one-cycle pulse at terminal count. The detector turns those two pulses into UP and DOWN requests for a charge pump.

New divide values arrive from serial shift logic outside the block. A load strobe copies them into a staging pair. The staged pair moves into the active divide registers only on a falling edge of the reference input, which gives the staged data half a reference period to settle. The running counters never restart in the middle of a period. A counter finishes the terminal count it has already started, and the new value takes effect when it next reloads. Because of this, a reload can never cut a reference period short or drop one, so the detector is never pushed into a long DOWN excursion.

A counter-reset input holds both counters and the detector idle. This lets a channel change be made repeatable: raise the hold, strobe the new values, let one reference falling edge pass, then release. Counting resumes from the new values.

Top module: `pll_divider_pair`

## Requirements
- R1: For as long as `rst_n` is low and on the cycle after it rises, `ref_div`, `fb_div`, `pfd_up` and `pfd_dn` are 0. Both active divide values start at 1.
- R2: With reference divide value D, `ref_div` is a single-cycle pulse on the cycle after every D-th counted rising edge of `ref_in`. A rising edge counts on the first clock at which `ref_in` is sampled high after being sampled low.
- R3: With feedback divide value D, `fb_div` is a single-cycle pulse on the cycle after every D-th counted rising edge of `fb_in`.
- R4: A staged divide value of 0 behaves exactly like a value of 1.
- R5: A clock with `load_stb` high copies `stage_r` and `stage_n` into the staging pair. The active values change only on a clock where `ref_in` is first sampled low after being sampled high. Until that happens, the old ratios stay in force.
- R6: A transfer leaves the running count alone. The period in progress ends with the old value, and the new value applies from the next terminal-count reload.
- R7: If the feedback divider reaches terminal count on the same clock as a transfer, it reloads with the newly transferred value.
- R8: While `cnt_hold` is high, both divider outputs and both detector outputs are 0 from the next cycle on, and edges are not counted. After release, the first pulse of each divider comes after exactly its active divide value of counted edges.
- R9: `pfd_up` goes to 1 on the cycle after a `ref_div` pulse, and `pfd_dn` goes to 1 on the cycle after an `fb_div` pulse. When both are 1, both are 0 on the next cycle.
- R10: A strobe that changes only the feedback value leaves the reference ratio unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference input level, synchronous to clk |
| fb_in | input | 1 | Feedback input level, synchronous to clk |
| stage_r | input | 14 | Reference divide value from the serial side |
| stage_n | input | 13 | Feedback divide value from the serial side |
| load_stb | input | 1 | Load strobe; captures stage_r and stage_n |
| cnt_hold | input | 1 | Holds counters and detector idle while high |
| ref_div | output | 1 | Divided reference pulse |
| fb_div | output | 1 | Divided feedback pulse |
| pfd_up | output | 1 | Charge-pump UP request |
| pfd_dn | output | 1 | Charge-pump DOWN request |

## Verification
The assertions assume that `ref_in` and `fb_in` are already synchronous to `clk` and that each stays at a level for at least one clock. Under that assumption, a counted edge can never occur on two clocks in a row, so a divider pulse always lasts exactly one cycle. The assertions also assume that the inputs hold defined levels through reset, because the edge detectors load the current input while reset is active. The stimulus changes inputs only on the falling clock edge. Each input level is held for at least one full clock, and both inputs stay low from time zero through reset. The sweeps run every divide value from 0 to 6 on both dividers, and directed sequences place a transfer in the middle of a count and at the same clock as a feedback terminal count.

// File: rtl/pll_div_pkg.sv
// Package: shared widths and the phase detector state encoding.
// Assumes: nothing; constants and types only.
package pll_div_pkg;

    // Default divider widths used by the top module parameters.
    localparam int REF_W_DEF = 14;
    localparam int FB_W_DEF  = 13;

    // Detector state; bit 0 drives UP, bit 1 drives DOWN.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10,
        PFD_BOTH = 2'b11
    } pfd_state_t;

endpackage

// File: rtl/pll_edge_detect.sv
// Module: single-edge detector for a level input already synchronous to clk.
// Emits a combinational one-cycle event on the clock where the input is
// first seen at its new level. FALLING selects which transition is reported.
// Assumes: input is synchronous; during reset the history follows the input
// so that no edge is reported on the first cycle after reset.
module pll_edge_detect #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic evt
);

    logic prev_q;

    // History register: follows the input, including during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= lvl;
        end else begin
            prev_q <= lvl;
        end
    end

    // Select the transition that this instance reports.
    generate
        if (FALLING) begin : g_fall
            assign evt = prev_q & ~lvl;
        end else begin : g_rise
            assign evt = ~prev_q & lvl;
        end
    endgenerate

endmodule

// File: rtl/pll_divide_counter.sv
// Module: down-counting event divider with deferred reload.
// Counts step events and emits a registered one-cycle tick on the event that
// reaches terminal count (count of 1). It then loads reload_val. A new divide
// value therefore only takes effect at a terminal count, and a period already
// in progress is never cut short.
// Assumes: reload_val is never 0; step is never high on two clocks in a row.
module pll_divide_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic         tick
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // Count events; reload and tick at terminal count; preload while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
            tick  <= 1'b0;
        end else if (hold) begin
            cnt_q <= reload_val;
            tick  <= 1'b0;
        end else if (step) begin
            if (cnt_q <= ONE) begin
                cnt_q <= reload_val;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/pll_pfd.sv
// Module: up/down phase-frequency detector on divider pulses.
// A reference pulse sets UP and a feedback pulse sets DOWN. When both are
// set, both clear on the following clock.
// Assumes: ref_pulse and fb_pulse are single-cycle pulses. A pulse that
// arrives on the clearing clock is absorbed by the clear.
module pll_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_pulse,
    input  logic fb_pulse,
    output logic up,
    output logic dn
);

    import pll_div_pkg::*;

    pfd_state_t st_q;
    pfd_state_t st_d;

    // Next-state: set on pulses, clear together once both are set.
    always_comb begin
        if (st_q == PFD_BOTH) begin
            st_d = PFD_IDLE;
        end else begin
            st_d = pfd_state_t'({st_q[1] | fb_pulse, st_q[0] | ref_pulse});
        end
    end

    // State register, forced idle by reset or counter hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            st_q <= PFD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign up = st_q[0];
    assign dn = st_q[1];

endmodule

// File: rtl/pll_divider_pair.sv
// Module: double-buffered reference and feedback dividers with detector.
// A load strobe captures the divide values into a staging pair. A reference
// falling edge moves the staged pair into the active registers. Each counter
// picks up its active value at its own next terminal count. If the feedback
// counter reaches terminal count on the transfer clock, it takes the staged
// value directly.
// Assumes: ref_in and fb_in are synchronous to clk and each level lasts at
// least one clock. The serial shift logic that drives stage_* is outside.
module pll_divider_pair #(
    parameter int R_W = pll_div_pkg::REF_W_DEF,
    parameter int N_W = pll_div_pkg::FB_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic           fb_in,
    input  logic [R_W-1:0] stage_r,
    input  logic [N_W-1:0] stage_n,
    input  logic           load_stb,
    input  logic           cnt_hold,
    output logic           ref_div,
    output logic           fb_div,
    output logic           pfd_up,
    output logic           pfd_dn
);

    localparam logic [R_W-1:0] R_ONE = R_W'(1);
    localparam logic [N_W-1:0] N_ONE = N_W'(1);

    logic           ref_rise;
    logic           ref_fall;
    logic           fb_rise;
    logic [R_W-1:0] pend_r;
    logic [N_W-1:0] pend_n;
    logic           pend_vld;
    logic [R_W-1:0] active_r;
    logic [N_W-1:0] active_n;
    logic [R_W-1:0] clean_r;
    logic [N_W-1:0] clean_n;
    logic           xfer;
    logic [R_W-1:0] reload_r;
    logic [N_W-1:0] reload_n;

    // Edge events on the reference and feedback levels.
    pll_edge_detect #(.FALLING(1'b0)) u_ref_rise (
        .clk(clk), .rst_n(rst_n), .lvl(ref_in), .evt(ref_rise)
    );
    pll_edge_detect #(.FALLING(1'b1)) u_ref_fall (
        .clk(clk), .rst_n(rst_n), .lvl(ref_in), .evt(ref_fall)
    );
    pll_edge_detect #(.FALLING(1'b0)) u_fb_rise (
        .clk(clk), .rst_n(rst_n), .lvl(fb_in), .evt(fb_rise)
    );

    // Map a zero divide value to one before it is staged.
    always_comb begin
        clean_r = (stage_r == '0) ? R_ONE : stage_r;
        clean_n = (stage_n == '0) ? N_ONE : stage_n;
    end

    // A transfer happens only on a reference falling edge with data pending.
    assign xfer = pend_vld & ref_fall;

    // Staging pair: captured on the strobe, marked consumed by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_r   <= R_ONE;
            pend_n   <= N_ONE;
            pend_vld <= 1'b0;
        end else if (load_stb) begin
            pend_r   <= clean_r;
            pend_n   <= clean_n;
            pend_vld <= 1'b1;
        end else if (xfer) begin
            pend_vld <= 1'b0;
        end
    end

    // Active pair: updated from staging only on the reference falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_r <= R_ONE;
            active_n <= N_ONE;
        end else if (xfer) begin
            active_r <= pend_r;
            active_n <= pend_n;
        end
    end

    // Reload source: the staged pair bypasses the active pair on a transfer clock.
    always_comb begin
        reload_r = xfer ? pend_r : active_r;
        reload_n = xfer ? pend_n : active_n;
    end

    // Reference divider: counts reference rising edges.
    pll_divide_counter #(.W(R_W)) u_ref_cnt (
        .clk(clk), .rst_n(rst_n), .hold(cnt_hold), .step(ref_rise),
        .reload_val(reload_r), .tick(ref_div)
    );

    // Feedback divider: counts feedback rising edges.
    pll_divide_counter #(.W(N_W)) u_fb_cnt (
        .clk(clk), .rst_n(rst_n), .hold(cnt_hold), .step(fb_rise),
        .reload_val(reload_n), .tick(fb_div)
    );

    // Phase-frequency detector on the two divided pulses.
    pll_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .hold(cnt_hold),
        .ref_pulse(ref_div), .fb_pulse(fb_div),
        .up(pfd_up), .dn(pfd_dn)
    );

endmodule

// File: rtl/pll_divider_pair_checker.sv
// Module: property checker for pll_divider_pair, attached by bind.
// Assumes: level inputs are synchronous and each level lasts at least one clock.
module pll_divider_pair_checker #(
    parameter int R_W = 14,
    parameter int N_W = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ref_in,
    input logic           cnt_hold,
    input logic           ref_div,
    input logic           fb_div,
    input logic           pfd_up,
    input logic           pfd_dn,
    input logic [R_W-1:0] active_r,
    input logic [N_W-1:0] active_n
);

    // R2: a reference pulse lasts one cycle.
    p_ref_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div |=> !ref_div);

    // R2: a reference pulse follows a rising edge on the previous clock.
    p_ref_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div |-> ($past(ref_in) && !$past(ref_in, 2)));

    // R3: a feedback pulse lasts one cycle.
    p_fb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_div |=> !fb_div);

    // R4: active divide values are never zero.
    p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_r != '0) && (active_n != '0));

    // R5: active values change only after a reference falling edge.
    p_xfer_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(active_r) || !$stable(active_n)) |->
            ($past(ref_in, 2) && !$past(ref_in)));

    // R8: hold silences both dividers and the detector.
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hold |=> (!ref_div && !fb_div && !pfd_up && !pfd_dn));

    // R9: UP follows a reference pulse unless a clear is in progress.
    p_up_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_div && !cnt_hold && !(pfd_up && pfd_dn)) |=> pfd_up);

    // R9: DOWN follows a feedback pulse unless a clear is in progress.
    p_dn_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_div && !cnt_hold && !(pfd_up && pfd_dn)) |=> pfd_dn);

    // R9: UP and DOWN together clear on the next clock.
    p_both_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pfd_up && pfd_dn) |=> (!pfd_up && !pfd_dn));

endmodule

bind pll_divider_pair pll_divider_pair_checker #(.R_W(R_W), .N_W(N_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cnt_hold(cnt_hold),
    .ref_div(ref_div), .fb_div(fb_div), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .active_r(active_r), .active_n(active_n)
);

// File: tb/test_pll_divider_pair.sv
module test_pll_divider_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        fb_in = 1'b0;
    logic [13:0] stage_r = '0;
    logic [12:0] stage_n = '0;
    logic        load_stb = 1'b0;
    logic        cnt_hold = 1'b0;
    logic        ref_div;
    logic        fb_div;
    logic        pfd_up;
    logic        pfd_dn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_divider_pair i_pll_divider_pair (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .stage_r(stage_r), .stage_n(stage_n), .load_stb(load_stb),
        .cnt_hold(cnt_hold), .ref_div(ref_div), .fb_div(fb_div),
        .pfd_up(pfd_up), .pfd_dn(pfd_dn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One reference period; hit is ref_div seen on the cycle after the rise.
    task automatic ref_period(output bit hit);
        @(negedge clk) ref_in = 1'b1;
        @(negedge clk) hit = ref_div;
        @(negedge clk) ref_in = 1'b0;
        @(negedge clk);
    endtask

    // One feedback pulse; hit is fb_div seen on the cycle after the rise.
    task automatic fb_pulse(output bit hit);
        @(negedge clk) fb_in = 1'b1;
        @(negedge clk) begin
            hit = fb_div;
            fb_in = 1'b0;
        end
        @(negedge clk);
    endtask

    // Load both divide values under hold; also checks that hold is quiet (R8).
    task automatic program_div(input int r, input int n);
        bit h;
        @(negedge clk) begin
            cnt_hold = 1'b1;
            stage_r = 14'(r);
            stage_n = 13'(n);
            load_stb = 1'b1;
        end
        @(negedge clk) load_stb = 1'b0;
        ref_period(h);
        check(h == 1'b0, "R8 hold ignores ref edge", int'(h), 0);
        check(!pfd_up && !pfd_dn, "R8 hold keeps detector idle", int'({pfd_dn, pfd_up}), 0);
        @(negedge clk);
        @(negedge clk) cnt_hold = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(input int r, input int n);
        @(negedge clk) begin
            stage_r = 14'(r);
            stage_n = 13'(n);
            load_stb = 1'b1;
        end
        @(negedge clk) load_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit h;
        int eff;

        repeat (3) @(negedge clk);
        check({ref_div, fb_div, pfd_up, pfd_dn} == 4'b0, "R1 outputs during reset",
              int'({ref_div, fb_div, pfd_up, pfd_dn}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ref_div, fb_div, pfd_up, pfd_dn} == 4'b0, "R1 outputs after reset",
              int'({ref_div, fb_div, pfd_up, pfd_dn}), 0);
        ref_period(h);
        check(h == 1'b1, "R1 default ref ratio 1", int'(h), 1);
        fb_pulse(h);
        check(h == 1'b1, "R1 default fb ratio 1", int'(h), 1);

        // R2 and R4: sweep reference divide 0..6 (0 behaves as 1).
        for (int r = 0; r <= 6; r++) begin
            eff = (r == 0) ? 1 : r;
            program_div(r, 1);
            for (int p = 1; p <= 3 * eff; p++) begin
                ref_period(h);
                check(h == ((p % eff) == 0), (r == 0) ? "R4 ref zero as one" : "R2 ref divide",
                      int'(h), int'((p % eff) == 0));
            end
        end

        // R3 and R4: sweep feedback divide 0..6 with the reference idle.
        for (int n = 0; n <= 6; n++) begin
            eff = (n == 0) ? 1 : n;
            program_div(1, n);
            for (int p = 1; p <= 3 * eff; p++) begin
                fb_pulse(h);
                check(h == ((p % eff) == 0), (n == 0) ? "R4 fb zero as one" : "R3 fb divide",
                      int'(h), int'((p % eff) == 0));
            end
        end

        // R6: reference change mid-period completes the old period first.
        program_div(3, 1);
        ref_period(h);
        check(h == 1'b0, "R6 period 1", int'(h), 0);
        strobe(5, 1);
        for (int p = 2; p <= 9; p++) begin
            ref_period(h);
            check(h == ((p == 3) || (p == 8)), "R6 old period then new",
                  int'(h), int'((p == 3) || (p == 8)));
        end

        // R5: staged N waits for a reference fall; R10: R ratio unchanged.
        program_div(2, 4);
        strobe(2, 2);
        for (int p = 1; p <= 8; p++) begin
            fb_pulse(h);
            check(h == ((p % 4) == 0), "R5 no change before fall", int'(h), int'((p % 4) == 0));
        end
        ref_period(h);
        check(h == 1'b0, "R10 ref count 1 of 2", int'(h), 0);
        for (int p = 9; p <= 14; p++) begin
            fb_pulse(h);
            check(h == ((p == 12) || (p == 14)), "R5 new N after fall",
                  int'(h), int'((p == 12) || (p == 14)));
        end
        for (int p = 2; p <= 5; p++) begin
            ref_period(h);
            check(h == ((p % 2) == 0), "R10 ref ratio kept", int'(h), int'((p % 2) == 0));
        end

        // R7: feedback terminal count on the transfer clock takes the new value.
        program_div(1, 3);
        fb_pulse(h);
        fb_pulse(h);
        check(h == 1'b0, "R7 fb count 2 of 3", int'(h), 0);
        strobe(1, 2);
        @(negedge clk) ref_in = 1'b1;
        @(negedge clk);
        @(negedge clk) begin
            ref_in = 1'b0;
            fb_in = 1'b1;
        end
        @(negedge clk) begin
            h = fb_div;
            fb_in = 1'b0;
        end
        check(h == 1'b1, "R7 terminal on transfer", int'(h), 1);
        @(negedge clk);
        fb_pulse(h);
        check(h == 1'b0, "R7 new N pulse 1", int'(h), 0);
        fb_pulse(h);
        check(h == 1'b1, "R7 new N pulse 2", int'(h), 1);

        // R9: detector timing with both ratios at 1.
        program_div(1, 1);
        check(!pfd_up && !pfd_dn, "R8 detector idle after release", int'({pfd_dn, pfd_up}), 0);
        @(negedge clk) ref_in = 1'b1;
        @(negedge clk);
        check(ref_div && !pfd_up, "R9 up not yet", int'(pfd_up), 0);
        @(negedge clk) ref_in = 1'b0;
        check(pfd_up && !pfd_dn, "R9 up set", int'({pfd_dn, pfd_up}), 1);
        @(negedge clk) fb_in = 1'b1;
        @(negedge clk) fb_in = 1'b0;
        check(fb_div && pfd_up && !pfd_dn, "R9 dn not yet", int'({pfd_dn, pfd_up}), 1);
        @(negedge clk);
        check(pfd_up && pfd_dn, "R9 both set", int'({pfd_dn, pfd_up}), 3);
        @(negedge clk);
        check(!pfd_up && !pfd_dn, "R9 both cleared", int'({pfd_dn, pfd_up}), 0);
        @(negedge clk);
        check(!pfd_up && !pfd_dn, "R9 stays idle", int'({pfd_dn, pfd_up}), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule